// File: doc/BRIEF.md
# Sparse Readout Frame Formatter

This block turns one accepted readout block (a channel address, one or more groups of pixel samples, and a timestamp for each group) into a serial stream of 6-bit words. Each output word is a 5-bit payload plus a 1-bit header flag. The header flag stays high for every word of a block and drops for at least one cycle between blocks. The receiver finds block boundaries from the flag alone, so no length field is sent.

A block starts with the high and then the low half of the channel address. Every group follows, and each one opens with an all-zero gap word, then its own three timestamp words, then its six data words. The gap word in front of the second and later groups tells the receiver that a new timestamp follows, and the header flag does not fall there. Blocks enter through a valid/ready handshake. The output side is held by a downstream ready signal: while ready is low, the current word stays on the port unchanged.

Top module: `sr_frame_fmt`

## Requirements
- R1: While reset is applied and on the first cycle after it, `out_hdr` is 0, `out_data` is 00000 and `blk_ready` is 1.
- R2: Whenever `out_hdr` is 0, `out_data` is 00000.
- R3: A block's words leave in this order: channel bits [9:5], channel bits [4:0], a gap word 00000, the first group's timestamp as three 5-bit words with the most significant first (stamp bits [14:10], [9:5], [4:0] of group slice 0), then six data words. Data word k of group g is `blk_pix[(g*6+k)*5 +: 5]`, and group g's timestamp is `blk_stamp[g*15 +: 15]`.
- R4: When `blk_ngrp_m1` is greater than 0, each further group g (in rising order) follows the previous group's last data word as a gap word 00000, then group g's three timestamp words with the most significant first, then its six data words.
- R5: `out_hdr` is 1 on every cycle from the first word of a block to the transfer of its last word, with no break at gap words or during stalls.
- R6: A word is transferred on a rising edge where `out_hdr` and `out_ready` are both 1. When `out_hdr` is 1 and `out_ready` is 0, the next cycle shows the same `out_data` with `out_hdr` still 1.
- R7: After the last word of a block is transferred, `out_hdr` is 0 and `blk_ready` is 1 on the next cycle. The first word of a block accepted on an edge appears on the cycle after that edge.
- R8: A block with `blk_ngrp_m1` = n contains exactly 2 + 10*(n+1) header-high transferred words.
- R9: `blk_ready` is 0 while a block is being sent. Changes on the block inputs during that time have no effect on the words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_valid | input | 1 | A block is offered on the block inputs |
| blk_ready | output | 1 | The formatter is idle and takes the offered block |
| blk_chan | input | 10 | Channel address; sent as the upper five bits, then the lower five |
| blk_ngrp_m1 | input | 2 | Number of groups minus one |
| blk_stamp | input | 60 | Timestamp of group g in bits [g*15 +: 15] |
| blk_pix | input | 120 | Data word k of group g in bits [(g*6+k)*5 +: 5] |
| out_ready | input | 1 | Downstream takes the current word |
| out_hdr | output | 1 | Header flag, high for every word of a block |
| out_data | output | 5 | Word payload |

## Verification
If the position state is wrong, a wrong word appears on `out_data` in the same cycle. Data, timestamp, address or gap words then arrive out of order and are reported on the first misplaced word. If the group counter or the end-of-block decision is wrong, the header flag falls early or late. This shows at the first cycle where `out_hdr` differs from the expected block length, and again as a mismatch in the word count when the flag falls. If a stall leaks through or the capture logic is broken, the word after the stalled or changed cycle differs, because the stimulus changes the offered block on every busy cycle.

// File: rtl/sr_fmt_pkg.sv
package sr_fmt_pkg;

  localparam int WORD_W = 5;

  typedef enum logic [2:0] {
    PH_AH  = 3'd0,
    PH_AL  = 3'd1,
    PH_GAP = 3'd2,
    PH_TS  = 3'd3,
    PH_DAT = 3'd4
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sr_blk_store.sv
module sr_blk_store
  import sr_fmt_pkg::*;
#(
  parameter int TS_WORDS      = 3,
  parameter int WORDS_PER_GRP = 6,
  parameter int MAX_GRPS      = 4,
  localparam int TS_W  = TS_WORDS * WORD_W,
  localparam int GRP_W = cnt_width(MAX_GRPS),
  localparam int PIX_W = MAX_GRPS * WORDS_PER_GRP * WORD_W,
  localparam int STP_W = MAX_GRPS * TS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [2*WORD_W-1:0] in_chan,
  input  logic [GRP_W-1:0]    in_ngrp_m1,
  input  logic [STP_W-1:0]    in_stamp,
  input  logic [PIX_W-1:0]    in_pix,
  output logic [2*WORD_W-1:0] st_chan,
  output logic [GRP_W-1:0]    st_ngrp_m1,
  output logic [STP_W-1:0]    st_stamp,
  output logic [PIX_W-1:0]    st_pix
);

  // Limit a group count to what the store can hold.
  function automatic logic [GRP_W-1:0] clamp_grp(input logic [GRP_W-1:0] n);
    if (int'(n) > MAX_GRPS - 1) return GRP_W'(MAX_GRPS - 1);
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_chan    <= '0;
      st_ngrp_m1 <= '0;
      st_stamp   <= '0;
      st_pix     <= '0;
    end else if (load) begin
      st_chan    <= in_chan;
      st_ngrp_m1 <= clamp_grp(in_ngrp_m1);
      st_stamp   <= in_stamp;
      st_pix     <= in_pix;
    end
  end

  // R9
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(st_pix) && $stable(st_chan) && $stable(st_stamp));

endmodule

// File: rtl/sr_frame_seq.sv
module sr_frame_seq
  import sr_fmt_pkg::*;
#(
  parameter int TS_WORDS      = 3,
  parameter int WORDS_PER_GRP = 6,
  parameter int MAX_GRPS      = 4,
  localparam int GRP_W = cnt_width(MAX_GRPS),
  localparam int SUB_W = cnt_width(max2(TS_WORDS, WORDS_PER_GRP))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [GRP_W-1:0] ngrp_m1,
  output logic             busy,
  output phase_e           phase,
  output logic [SUB_W-1:0] sub,
  output logic [GRP_W-1:0] grp,
  output logic             last_word
);

  localparam logic [SUB_W-1:0] TS_LAST  = SUB_W'(TS_WORDS - 1);
  localparam logic [SUB_W-1:0] DAT_LAST = SUB_W'(WORDS_PER_GRP - 1);

  logic   ts_end, dat_end, grp_end;
  logic   busy_n;
  phase_e phase_n;
  logic [SUB_W-1:0] sub_n;
  logic [GRP_W-1:0] grp_n;

  assign ts_end    = (phase == PH_TS)  && (sub == TS_LAST);
  assign dat_end   = (phase == PH_DAT) && (sub == DAT_LAST);
  assign grp_end   = (grp == ngrp_m1);
  assign last_word = busy && dat_end && grp_end;

  always_comb begin
    busy_n  = busy;
    phase_n = phase;
    sub_n   = sub;
    grp_n   = grp;
    if (!busy) begin
      if (start) begin
        busy_n  = 1'b1;
        phase_n = PH_AH;
        sub_n   = '0;
        grp_n   = '0;
      end
    end else if (step) begin
      unique case (phase)
        PH_AH:  phase_n = PH_AL;
        PH_AL:  phase_n = PH_GAP;
        PH_GAP: begin
          phase_n = PH_TS;
          sub_n   = '0;
        end
        PH_TS: begin
          if (ts_end) begin
            phase_n = PH_DAT;
            sub_n   = '0;
          end else begin
            sub_n = sub + 1'b1;
          end
        end
        PH_DAT: begin
          if (!dat_end) begin
            sub_n = sub + 1'b1;
          end else if (grp_end) begin
            busy_n  = 1'b0;
            phase_n = PH_AH;
            sub_n   = '0;
            grp_n   = '0;
          end else begin
            phase_n = PH_GAP;
            sub_n   = '0;
            grp_n   = grp + 1'b1;
          end
        end
        default: phase_n = PH_AH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= PH_AH;
      sub   <= '0;
      grp   <= '0;
    end else begin
      busy  <= busy_n;
      phase <= phase_n;
      sub   <= sub_n;
      grp   <= grp_n;
    end
  end

  // R4
  next_group_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dat_end && !grp_end && step |=> busy && phase == PH_GAP && grp == $past(grp) + 1'b1);

  // R3
  ts_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ts_end && step |=> phase == PH_DAT && sub == '0);

  // R8
  grp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> grp <= ngrp_m1);

  // R3
  frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && phase == PH_AH && grp == '0);

endmodule

// File: rtl/sr_word_sel.sv
module sr_word_sel
  import sr_fmt_pkg::*;
#(
  parameter int TS_WORDS      = 3,
  parameter int WORDS_PER_GRP = 6,
  parameter int MAX_GRPS      = 4,
  localparam int TS_W  = TS_WORDS * WORD_W,
  localparam int GRP_W = cnt_width(MAX_GRPS),
  localparam int SUB_W = cnt_width(max2(TS_WORDS, WORDS_PER_GRP)),
  localparam int PIX_W = MAX_GRPS * WORDS_PER_GRP * WORD_W,
  localparam int STP_W = MAX_GRPS * TS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              phase,
  input  logic [SUB_W-1:0]    sub,
  input  logic [GRP_W-1:0]    grp,
  input  logic [2*WORD_W-1:0] chan,
  input  logic [STP_W-1:0]    stamp,
  input  logic [PIX_W-1:0]    pix,
  output logic [WORD_W-1:0]   word
);

  // Bit offset of data word k in group g.
  function automatic int pix_base(input int g, input int k);
    return (g * WORDS_PER_GRP + k) * WORD_W;
  endfunction

  // Bit offset of timestamp word k of group g; word 0 is the most significant.
  function automatic int ts_base(input int g, input int k);
    return g * TS_W + (TS_WORDS - 1 - k) * WORD_W;
  endfunction

  logic [WORD_W-1:0] pix_w [MAX_GRPS][WORDS_PER_GRP];
  logic [WORD_W-1:0] ts_w  [MAX_GRPS][TS_WORDS];

  for (genvar g = 0; g < MAX_GRPS; g++) begin : g_grp
    for (genvar k = 0; k < WORDS_PER_GRP; k++) begin : g_pix
      assign pix_w[g][k] = pix[pix_base(g, k) +: WORD_W];
    end
    for (genvar k = 0; k < TS_WORDS; k++) begin : g_ts
      assign ts_w[g][k] = stamp[ts_base(g, k) +: WORD_W];
    end
  end

  always_comb begin
    word = '0;
    unique case (phase)
      PH_AH:  word = chan[2*WORD_W-1:WORD_W];
      PH_AL:  word = chan[WORD_W-1:0];
      PH_GAP: word = '0;
      PH_TS:  if (int'(sub) < TS_WORDS) word = ts_w[grp][sub];
      PH_DAT: if (int'(sub) < WORDS_PER_GRP) word = pix_w[grp][sub];
      default: word = '0;
    endcase
  end

  // R4
  gap_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_GAP |-> word == '0);

endmodule

// File: rtl/sr_frame_fmt.sv
module sr_frame_fmt
  import sr_fmt_pkg::*;
#(
  parameter int TS_WORDS      = 3,
  parameter int WORDS_PER_GRP = 6,
  parameter int MAX_GRPS      = 4,
  localparam int TS_W  = TS_WORDS * WORD_W,
  localparam int GRP_W = cnt_width(MAX_GRPS),
  localparam int SUB_W = cnt_width(max2(TS_WORDS, WORDS_PER_GRP)),
  localparam int PIX_W = MAX_GRPS * WORDS_PER_GRP * WORD_W,
  localparam int STP_W = MAX_GRPS * TS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_valid,
  output logic                blk_ready,
  input  logic [2*WORD_W-1:0] blk_chan,
  input  logic [GRP_W-1:0]    blk_ngrp_m1,
  input  logic [STP_W-1:0]    blk_stamp,
  input  logic [PIX_W-1:0]    blk_pix,
  input  logic                out_ready,
  output logic                out_hdr,
  output logic [WORD_W-1:0]   out_data
);

  logic                busy;
  logic                accept;
  logic                last_word;
  logic                last_xfer;
  phase_e              phase;
  logic [SUB_W-1:0]    sub;
  logic [GRP_W-1:0]    grp;
  logic [2*WORD_W-1:0] st_chan;
  logic [GRP_W-1:0]    st_ngrp_m1;
  logic [STP_W-1:0]    st_stamp;
  logic [PIX_W-1:0]    st_pix;
  logic [WORD_W-1:0]   cur_word;

  assign blk_ready = !busy;
  assign accept    = blk_valid && !busy;
  assign last_xfer = last_word && out_ready;

  sr_blk_store #(
    .TS_WORDS(TS_WORDS), .WORDS_PER_GRP(WORDS_PER_GRP), .MAX_GRPS(MAX_GRPS)
  ) i_store (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .in_chan(blk_chan), .in_ngrp_m1(blk_ngrp_m1),
    .in_stamp(blk_stamp), .in_pix(blk_pix),
    .st_chan(st_chan), .st_ngrp_m1(st_ngrp_m1),
    .st_stamp(st_stamp), .st_pix(st_pix)
  );

  sr_frame_seq #(
    .TS_WORDS(TS_WORDS), .WORDS_PER_GRP(WORDS_PER_GRP), .MAX_GRPS(MAX_GRPS)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .step(out_ready),
    .ngrp_m1(st_ngrp_m1), .busy(busy), .phase(phase), .sub(sub),
    .grp(grp), .last_word(last_word)
  );

  sr_word_sel #(
    .TS_WORDS(TS_WORDS), .WORDS_PER_GRP(WORDS_PER_GRP), .MAX_GRPS(MAX_GRPS)
  ) i_sel (
    .clk(clk), .rst_n(rst_n), .phase(phase), .sub(sub), .grp(grp),
    .chan(st_chan), .stamp(st_stamp), .pix(st_pix), .word(cur_word)
  );

  assign out_hdr  = busy;
  assign out_data = busy ? cur_word : '0;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hdr && !out_ready |=> out_hdr && $stable(out_data));

  // R5
  hdr_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hdr && !last_xfer |=> out_hdr);

  // R7
  idle_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_xfer |=> !out_hdr && blk_ready);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hdr |-> out_data == '0);

  // R9
  busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hdr |-> !blk_ready);

  // R7
  start_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready |=> out_hdr);

endmodule

// File: tb/test_sr_frame_fmt.sv
`timescale 1ns/1ps
module test_sr_frame_fmt;

  localparam int W   = 5;
  localparam int TSN = 3;
  localparam int WPG = 6;
  localparam int MG  = 4;

  logic         clk;
  logic         rst_n;
  logic         blk_valid;
  logic         blk_ready;
  logic [9:0]   blk_chan;
  logic [1:0]   blk_ngrp_m1;
  logic [59:0]  blk_stamp;
  logic [119:0] blk_pix;
  logic         out_ready;
  logic         out_hdr;
  logic [4:0]   out_data;

  sr_frame_fmt i_sr_frame_fmt (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_chan(blk_chan), .blk_ngrp_m1(blk_ngrp_m1), .blk_stamp(blk_stamp),
    .blk_pix(blk_pix), .out_ready(out_ready), .out_hdr(out_hdr),
    .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    q[$];
  string qt[$];
  bit    exp_busy = 0;
  bit    prev_hdr = 0;
  bit    prev_stall = 0;
  int    prev_data = 0;
  int    run_cnt = 0;
  int    exp_len = 0;
  int    ready_mode = 0;
  int    cyc = 0;
  bit    in_reset = 1;
  bit    reported = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    end
  endtask

  // Expected words for the block presented right now.
  task automatic build_expected();
    int ng;
    ng = int'(blk_ngrp_m1) + 1;
    exp_len = 2 + 10 * ng;
    q.push_back(int'(blk_chan) / 32);        qt.push_back("R3 addr-high");
    q.push_back(int'(blk_chan) % 32);        qt.push_back("R3 addr-low");
    for (int g = 0; g < ng; g++) begin
      int stamp_v;
      stamp_v = int'((blk_stamp >> (g * 15)) & 60'h7FFF);
      q.push_back(0);                        qt.push_back(g == 0 ? "R3 gap" : "R4 gap");
      q.push_back((stamp_v / 1024) % 32);    qt.push_back(g == 0 ? "R3 ts" : "R4 ts");
      q.push_back((stamp_v / 32) % 32);      qt.push_back(g == 0 ? "R3 ts" : "R4 ts");
      q.push_back(stamp_v % 32);             qt.push_back(g == 0 ? "R3 ts" : "R4 ts");
      for (int k = 0; k < WPG; k++) begin
        q.push_back(int'((blk_pix >> ((g * WPG + k) * W)) & 120'h1F));
        qt.push_back(g == 0 ? "R3 data" : "R4 data");
      end
    end
  endtask

  // Reference model: check on the falling edge, then advance for the next rising edge.
  always @(negedge clk) begin
    cyc++;
    if (in_reset) begin
      chk(out_hdr == 1'b0, "R1 hdr", out_hdr, 0);
      chk(out_data == 5'd0, "R1 data", out_data, 0);
      chk(blk_ready == 1'b1, "R1 ready", blk_ready, 1);
    end else begin
      chk(out_hdr == exp_busy, "R5 hdr", out_hdr, exp_busy);
      chk(blk_ready == !exp_busy, "R9 ready", blk_ready, !exp_busy);
      if (exp_busy && q.size() > 0)
        chk(out_data == q[0], qt[0], out_data, q[0]);
      else
        chk(out_data == 5'd0, "R2 idle data", out_data, 0);
      if (prev_stall && out_hdr)
        chk(int'(out_data) == prev_data, "R6 stall hold", out_data, prev_data);
      if (prev_hdr && !out_hdr) begin
        chk(run_cnt == exp_len, "R8 length", run_cnt, exp_len);
        chk(blk_ready == 1'b1, "R7 ready after block", blk_ready, 1);
      end
      if (!out_hdr) run_cnt = 0;
      else if (out_ready) run_cnt++;
      prev_hdr   = out_hdr;
      prev_stall = out_hdr && !out_ready;
      prev_data  = int'(out_data);
      if (exp_busy) begin
        if (out_ready) begin
          void'(q.pop_front());
          void'(qt.pop_front());
          if (q.size() == 0) exp_busy = 0;
        end
      end else if (blk_valid) begin
        build_expected();
        exp_busy = 1;
      end
    end
  end

  // Downstream ready patterns.
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ((cyc * 7) % 5) != 0;
        default: out_ready = (cyc % 4) == 0;
      endcase
    end
  end

  // Offer one block; while waiting, the offered block changes every cycle (R9).
  task automatic send_block(input logic [9:0] a, input int ngm1, input int seed);
    bit acc;
    blk_chan    = a;
    blk_ngrp_m1 = 2'(ngm1);
    for (int i = 0; i < MG * WPG; i++) blk_pix[i*W +: W] = 5'((seed * 7 + i * 13) & 31);
    for (int g = 0; g < MG; g++) blk_stamp[g*15 +: 15] = 15'((seed * 1001 + g * 4567) & 32'h7FFF);
    blk_valid = 1'b1;
    do begin
      @(negedge clk);
      acc = blk_ready;
      @(posedge clk);
      #1;
      if (!acc) begin
        blk_pix   = blk_pix ^ {4{30'h2A5A_5A5A}};
        blk_stamp = blk_stamp + 60'h0421_0842_1084_2108;
        blk_chan  = blk_chan ^ 10'h155;
      end
    end while (!acc);
    blk_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    blk_valid = 1'b0;
    blk_chan = '0;
    blk_ngrp_m1 = '0;
    blk_stamp = '0;
    blk_pix = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    in_reset = 0;
    @(posedge clk);
    #1;
    repeat (3) @(posedge clk);
    #1;
    // Full-speed downstream: single group, two groups, four groups, extreme addresses.
    ready_mode = 0;
    send_block(10'h3A5, 0, 1);
    send_block(10'h000, 1, 2);
    send_block(10'h3FF, 3, 3);
    send_block(10'h21F, 2, 4);
    repeat (40) @(posedge clk);
    #1;
    // Occasional stalls.
    ready_mode = 1;
    send_block(10'h155, 1, 5);
    send_block(10'h2AA, 0, 6);
    send_block(10'h0C3, 3, 7);
    repeat (60) @(posedge clk);
    #1;
    // Heavy stalls.
    ready_mode = 2;
    send_block(10'h1E0, 3, 8);
    send_block(10'h01F, 0, 9);
    repeat (200) @(posedge clk);
    #1;
    ready_mode = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R8 all words sent", q.size(), 0);
    chk(out_hdr == 1'b0, "R2 final idle", out_hdr, 0);
    report();
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

endmodule